// File: doc/BRIEF.md
# Two-Dimensional Bypassing Array Multiplier

This block multiplies two unsigned operands of `N` bits each and returns the full `2N`-bit product. It contains no registers. An array of two-input AND gates forms every partial-product bit at once. Rows of carry-save adder cells then fold each new partial-product row into the shifted sum and carry vectors from the row above. A ripple-carry stage at the bottom merges the last sum and carry vectors into the upper half of the product.

Each adder cell can be skipped to save switching power. If its partial-product bit is zero and no carry is arriving from the row above, the cell forces its adder inputs to zero, hands the incoming sum bit straight through and sends out a zero carry. A cell that has a pending carry is never skipped, so the product stays exact.

A style parameter picks one of two cell builds. One uses a plain full adder. The other uses a pair of reduced adders: an incrementer for the case where only a carry is pending, and an add-plus-one cell for the case where the partial-product bit is set. The block exposes one skip flag per adder cell so that the surrounding logic can observe the bypass activity.

Top module: `bypass_array_mult`

## Requirements
- R1: For every pair of operands, `prod_o` equals the unsigned product `a_i * b_i`, using all `2N` bits.
- R2: The block is purely combinational: a new product and new skip flags follow a change of operands with no clock edge in between.
- R3: The skip flag of a cell whose partial-product bit is one is never set. The partial-product bit of the cell in adder row `j` (1 to N-1) and column `i` is `a_i[i] & b_i[j]`. The flag for that cell is `cell_skip_o[(j-1)*N + i]`.
- R4: In the first adder row (`j = 1`) no carries arrive, so each cell's skip flag is set exactly when its partial-product bit is zero.
- R5: When either operand is zero, every one of the `N*(N-1)` skip flags is set.
- R6: A cell is skipped only when its partial-product bit and its incoming carry are both zero. In every cell, the two-bit value (carry out, sum out) equals the partial-product bit plus the incoming sum plus the incoming carry. As a result, products made from sparse and dense bit patterns stay exact.
- R7: The final ripple stage never produces a carry beyond bit `2N-1`. For example, the largest operands give `(2^N-1)^2`.
- R8: Both cell styles (plain full adder, and split incrementer / add-plus-one) give the same products and skip flags. `N` is accepted from 2 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | Multiplicand, unsigned |
| b_i | input | N | Multiplier, unsigned |
| prod_o | output | 2N | Full unsigned product |
| cell_skip_o | output | N*(N-1) | One flag per adder cell; set while the cell is bypassed |

## Verification
Every result is due in the same cycle as its operands, because no register lies between the inputs and either output. The bench drives new operands shortly after a rising edge and samples the product and the skip flags at the following falling edge, half a period later. The expected product comes from bench arithmetic. The expected skip flags come from the partial-product bits, using the row-one and zero-operand rules. At N=4 every operand pair is swept for both cell styles. At N=8 the corner values are applied first, followed by random pairs.

// File: rtl/bam_pkg.sv
package bam_pkg;
   typedef enum logic [0:0] {
      CELL_FULL  = 1'b0,
      CELL_SPLIT = 1'b1
   } cell_style_e;

   localparam int unsigned MIN_WIDTH = 2;
   localparam int unsigned MAX_WIDTH = 8;
endpackage

// File: rtl/bam_pp_gen.sv
module bam_pp_gen #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0]   a_i,
   input  logic [N-1:0]   b_i,
   output logic [N*N-1:0] pp_o
);
   for (genvar j = 0; j < N; j++) begin : g_row
      for (genvar i = 0; i < N; i++) begin : g_col
         assign pp_o[j*N + i] = a_i[i] & b_i[j];
      end
   end
endmodule

// File: rtl/bam_cell.sv
module bam_cell #(
   parameter bam_pkg::cell_style_e STYLE = bam_pkg::CELL_SPLIT
) (
   input  logic pp_i,
   input  logic sum_i,
   input  logic carry_i,
   output logic sum_o,
   output logic carry_o,
   output logic skip_o
);
   logic g_pp, g_sum, g_carry;
   logic add_sum, add_carry;

   assign skip_o  = ~pp_i & ~carry_i;
   assign g_pp    = pp_i    & ~skip_o;
   assign g_sum   = sum_i   & ~skip_o;
   assign g_carry = carry_i & ~skip_o;

   if (STYLE == bam_pkg::CELL_FULL) begin : g_full
      assign add_sum   = g_pp ^ g_sum ^ g_carry;
      assign add_carry = (g_pp & g_sum) | (g_pp & g_carry) | (g_sum & g_carry);
   end else begin : g_split
      logic inc_sum, inc_carry, abp_sum, abp_carry;
      assign inc_sum   = ~g_sum;
      assign inc_carry = g_sum;
      assign abp_sum   = ~(g_sum ^ g_carry);
      assign abp_carry = g_sum | g_carry;
      assign add_sum   = g_pp ? abp_sum   : inc_sum;
      assign add_carry = g_pp ? abp_carry : inc_carry;
   end

   assign sum_o   = skip_o ? sum_i : add_sum;
   assign carry_o = skip_o ? 1'b0  : add_carry;

   always_comb begin
      if (!$isunknown({pp_i, sum_i, carry_i})) begin
         // R6
         cell_sum_chk: assert ({carry_o, sum_o} == 2'(pp_i) + 2'(sum_i) + 2'(carry_i))
            else $error("cell arithmetic mismatch");
      end
   end
endmodule

// File: rtl/bam_ripple.sv
module bam_ripple #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] sum_i,
   input  logic [N-1:0] carry_i,
   output logic [N-1:0] hi_o
);
   logic [N:0] rc;
   logic [N-1:0] upper_sum;

   assign upper_sum = {1'b0, sum_i[N-1:1]};

   always_comb begin
      rc[0] = 1'b0;
      for (int k = 0; k < N; k++) begin
         hi_o[k]  = upper_sum[k] ^ carry_i[k] ^ rc[k];
         rc[k+1]  = (upper_sum[k] & carry_i[k]) | (upper_sum[k] & rc[k]) | (carry_i[k] & rc[k]);
      end
   end

   always_comb begin
      if (!$isunknown({sum_i, carry_i})) begin
         // R7
         no_overflow_chk: assert (rc[N] == 1'b0)
            else $error("ripple stage carried out of the product");
      end
   end
endmodule

// File: rtl/bypass_array_mult.sv
module bypass_array_mult #(
   parameter int unsigned          N     = 4,
   parameter bam_pkg::cell_style_e STYLE = bam_pkg::CELL_SPLIT
) (
   input  logic [N-1:0]       a_i,
   input  logic [N-1:0]       b_i,
   output logic [2*N-1:0]     prod_o,
   output logic [N*(N-1)-1:0] cell_skip_o
);
   localparam int unsigned PW     = 2 * N;
   localparam int unsigned NCELLS = N * (N - 1);

   if (N < bam_pkg::MIN_WIDTH || N > bam_pkg::MAX_WIDTH) begin : g_bad_width
      $error("operand width out of supported range");
   end

   logic [N*N-1:0] pp;

   bam_pp_gen #(.N(N)) u_pp (
      .a_i  (a_i),
      .b_i  (b_i),
      .pp_o (pp)
   );

   for (genvar j = 0; j < N; j++) begin : g_row
      logic [N-1:0] s_v;
      logic [N-1:0] c_v;
      if (j == 0) begin : g_first
         assign s_v = pp[N-1:0];
         assign c_v = '0;
      end else begin : g_adders
         for (genvar i = 0; i < N; i++) begin : g_cell
            logic sum_in;
            if (i == N - 1) begin : g_edge
               assign sum_in = 1'b0;
            end else begin : g_inner
               assign sum_in = g_row[j-1].s_v[i+1];
            end
            bam_cell #(.STYLE(STYLE)) u_cell (
               .pp_i    (pp[j*N + i]),
               .sum_i   (sum_in),
               .carry_i (g_row[j-1].c_v[i]),
               .sum_o   (s_v[i]),
               .carry_o (c_v[i]),
               .skip_o  (cell_skip_o[(j-1)*N + i])
            );
         end
      end
      assign prod_o[j] = s_v[0];
   end

   bam_ripple #(.N(N)) u_final (
      .sum_i   (g_row[N-1].s_v),
      .carry_i (g_row[N-1].c_v),
      .hi_o    (prod_o[PW-1:N])
   );

   always_comb begin
      if (!$isunknown({a_i, b_i})) begin
         // R1
         product_chk: assert (prod_o == PW'(a_i) * PW'(b_i))
            else $error("product mismatch");
         // R5
         zero_op_chk: assert ((a_i != '0 && b_i != '0) || cell_skip_o == {NCELLS{1'b1}})
            else $error("zero operand left a cell active");
      end
   end

   for (genvar j = 1; j < N; j++) begin : g_skip_chk
      for (genvar i = 0; i < N; i++) begin : g_c
         always_comb begin
            if (!$isunknown({a_i[i], b_i[j]})) begin
               // R3
               skip_pp_chk: assert (!(a_i[i] && b_i[j]) || !cell_skip_o[(j-1)*N + i])
                  else $error("cell skipped with a set partial product");
            end
         end
      end
   end
endmodule

// File: tb/bypass_array_mult_bench.sv
module bypass_array_mult_bench;
   localparam int unsigned NS = 4;
   localparam int unsigned NW = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic [NS-1:0]         a4, b4;
   logic [2*NS-1:0]       p4, p4f;
   logic [NS*(NS-1)-1:0]  k4, k4f;
   logic [NW-1:0]         a8, b8;
   logic [2*NW-1:0]       p8;
   logic [NW*(NW-1)-1:0]  k8;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   bypass_array_mult #(.N(NS), .STYLE(bam_pkg::CELL_SPLIT)) u_bypass_array_mult (
      .a_i(a4), .b_i(b4), .prod_o(p4), .cell_skip_o(k4));
   bypass_array_mult #(.N(NS), .STYLE(bam_pkg::CELL_FULL)) u_full4 (
      .a_i(a4), .b_i(b4), .prod_o(p4f), .cell_skip_o(k4f));
   bypass_array_mult #(.N(NW), .STYLE(bam_pkg::CELL_SPLIT)) u_wide8 (
      .a_i(a8), .b_i(b8), .prod_o(p8), .cell_skip_o(k8));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic apply4(input int av, input int bv);
      logic [2*NS-1:0] exp_p;
      @(posedge clk);
      #2;
      a4 = NS'(av);
      b4 = NS'(bv);
      @(negedge clk);
      vectors++;
      exp_p = (2*NS)'(av * bv);
      // R1, R2: product due in the same cycle
      check(p4 == exp_p, "R1", p4, exp_p);
      // R8: both cell styles agree
      check(p4f == exp_p, "R8", p4f, exp_p);
      check(k4f == k4, "R8", k4f, k4);
      for (int j = 1; j < NS; j++) begin
         for (int i = 0; i < NS; i++) begin
            bit ppb = a4[i] & b4[j];
            // R3: a set partial product never skips
            if (ppb) check(!k4[(j-1)*NS+i], "R3", k4[(j-1)*NS+i], 0);
            // R4: first adder row skips exactly when its bit is zero
            if (j == 1) check(k4[i] == !ppb, "R4", k4[i], !ppb);
         end
      end
      // R5: zero operand skips everything
      if (av == 0 || bv == 0) check(&k4, "R5", k4, {NS*(NS-1){1'b1}});
      // R7: largest operands
      if (av == 15 && bv == 15) check(p4 == 8'd225, "R7", p4, 225);
   endtask

   task automatic apply8(input logic [NW-1:0] av, input logic [NW-1:0] bv, input string req);
      logic [2*NW-1:0] exp_p;
      @(posedge clk);
      #2;
      a8 = av;
      b8 = bv;
      @(negedge clk);
      vectors++;
      exp_p = (2*NW)'(av) * (2*NW)'(bv);
      check(p8 == exp_p, req, p8, exp_p);
      for (int i = 0; i < NW; i++)
         if (av[i] & bv[1]) check(!k8[i], "R3", k8[i], 0);
         else check(k8[i], "R4", k8[i], 1);
      if (av == 0 || bv == 0) check(&k8, "R5", k8, {NW*(NW-1){1'b1}});
   endtask

   initial begin
      a4 = '0; b4 = '0; a8 = '0; b8 = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      vectors++;
      check(p4 == '0 && &k4, "R5", {p4, k4}, {8'h0, 12'hfff});
      for (int av = 0; av < 16; av++)
         for (int bv = 0; bv < 16; bv++)
            apply4(av, bv);
      apply8(8'hff, 8'hff, "R7");
      apply8(8'h00, 8'hff, "R5");
      apply8(8'hff, 8'h00, "R5");
      // R6: dense carries against sparse rows
      apply8(8'hff, 8'h81, "R6");
      apply8(8'h80, 8'hff, "R6");
      apply8(8'haa, 8'h55, "R6");
      apply8(8'hfe, 8'h7f, "R6");
      for (int n = 0; n < 3000; n++)
         apply8(NW'($urandom), NW'($urandom), "R1");
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         miscompares++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule